// File: doc/BRIEF.md
# Key Autorepeat Code Injector

This block sits between a key-matrix debouncer and a key-event FIFO. While at least one key stays held, it writes a fixed repeat code into the FIFO. The first code comes after a programmable delay, counted from the most recent key event. Further codes follow at a programmable period. It never writes the held key's own code again.

Time is counted in debounce-cycle ticks, which arrive as single-cycle pulses on `tick_i`. A press or release event restarts the schedule, provided some key is still held. If no key is held, or the feature is disabled, the block stays idle. When the FIFO is full at the moment a code is due, that code is dropped and the schedule carries on unchanged.

Top module: `key_autorepeat`

## Requirements
- R1: After reset, `fifo_wr_o` stays low until the feature is enabled and a key is held long enough for a code to fall due.
- R2: Every write carries the code 0x7E on `fifo_data_o`; in cycles without a write, `fifo_data_o` is 0x00.
- R3: Configuration bit 7 is the enable (1 = on, 0 = off). With bit 7 clear, nothing is written. Clearing it mid-sequence stops writes from the next clock edge. Setting it again while a key is held starts a fresh delay.
- R4: Let D = (cfg[3:0]+1)*8. The first code is written after the D-th tick that follows the last key event. With the feature already enabled, the same count applies after the cycle in which `key_held_i` rises.
- R5: Let P = (cfg[6:4]+1)*4. After the first code, a further code is written every P ticks for as long as no key event occurs.
- R6: A key event (`key_evt_i`) in any cycle with `key_held_i` high restarts the delay count from zero. An event coinciding with a due tick suppresses that code.
- R7: While `key_held_i` is low, the block is idle and writes nothing, even with ticks and events arriving.
- R8: If `fifo_full_i` is high on the tick when a code is due, that code is not written, and the next code still falls exactly P ticks later.
- R9: `fifo_wr_o` is a one-cycle pulse. It rises only in the cycle after a clock edge at which `tick_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 8 | [7] enable, [6:4] period code, [3:0] delay code |
| tick_i | input | 1 | One-cycle pulse per debounce cycle |
| key_evt_i | input | 1 | Key press or release event strobe |
| key_held_i | input | 1 | At least one debounced key is down |
| fifo_full_i | input | 1 | Key-event FIFO cannot accept a write |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write data |

## Verification
The checker watches every cycle for properties that hold cycle by cycle. It checks that each write carries 0x7E. It checks that each write follows a clock edge with a tick, enable, a held key, a non-full FIFO and no key event. It also checks that strobes are never back to back.

Some behaviour depends on counting ticks, so only the bench scenarios can show it. These are the exact delay and period for every configuration code, and that a dropped code keeps its phase. They also cover the restart after an event or after re-enable, and idling with no key held.

// File: rtl/key_ar_pkg.sv
package key_ar_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] REPEAT_CODE = 8'h7E;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DELAY  = 2'd1,
    PH_REPEAT = 2'd2
  } ar_phase_e;
endpackage

// File: rtl/ar_period_sel.sv
module ar_period_sel #(
  parameter int unsigned DLY_W     = 4,
  parameter int unsigned RATE_W    = 3,
  parameter int unsigned DLY_UNIT  = 8,
  parameter int unsigned RATE_UNIT = 4,
  parameter int unsigned CNT_W     = 8
) (
  input  logic [DLY_W-1:0]  dly_code_i,
  input  logic [RATE_W-1:0] rate_code_i,
  input  logic              repeat_phase_i,
  output logic [CNT_W-1:0]  limit_o
);
  logic [CNT_W-1:0] dly_ticks, rate_ticks;

  always_comb begin
    dly_ticks  = CNT_W'((32'(dly_code_i) + 32'd1) * DLY_UNIT);
    rate_ticks = CNT_W'((32'(rate_code_i) + 32'd1) * RATE_UNIT);
    limit_o    = repeat_phase_i ? rate_ticks : dly_ticks;
  end
endmodule

// File: rtl/ar_tick_timer.sv
module ar_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit_o   = adv_i && (cnt_inc == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (hit_o)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/key_autorepeat.sv
module key_autorepeat
  import key_ar_pkg::*;
#(
  parameter int unsigned DLY_W     = 4,
  parameter int unsigned RATE_W    = 3,
  parameter int unsigned DLY_UNIT  = 8,
  parameter int unsigned RATE_UNIT = 4,
  localparam int unsigned CFG_W    = 1 + RATE_W + DLY_W,
  localparam int unsigned DLY_MAX  = (2 ** DLY_W) * DLY_UNIT,
  localparam int unsigned RATE_MAX = (2 ** RATE_W) * RATE_UNIT,
  localparam int unsigned CNT_W    = $clog2(((DLY_MAX > RATE_MAX) ? DLY_MAX : RATE_MAX) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              tick_i,
  input  logic              key_evt_i,
  input  logic              key_held_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o
);
  ar_phase_e        phase_q, phase_d;
  logic             enable, run, clr, adv, hit;
  logic [CNT_W-1:0] limit;
  logic             wr_q;

  assign enable = cfg_i[CFG_W-1];
  assign run    = enable && key_held_i;
  // any event or a fresh start resets the count; idle never advances
  assign clr    = !run || key_evt_i || (phase_q == PH_IDLE);
  assign adv    = !clr && tick_i;

  ar_period_sel #(
    .DLY_W(DLY_W), .RATE_W(RATE_W), .DLY_UNIT(DLY_UNIT),
    .RATE_UNIT(RATE_UNIT), .CNT_W(CNT_W)
  ) u_sel (
    .dly_code_i     (cfg_i[DLY_W-1:0]),
    .rate_code_i    (cfg_i[DLY_W +: RATE_W]),
    .repeat_phase_i (phase_q == PH_REPEAT),
    .limit_o        (limit)
  );

  ar_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .adv_i   (adv),
    .limit_i (limit),
    .hit_o   (hit)
  );

  always_comb begin
    phase_d = phase_q;
    if (!run)                                phase_d = PH_IDLE;
    else if (key_evt_i || phase_q == PH_IDLE) phase_d = PH_DELAY;
    else if (hit)                            phase_d = PH_REPEAT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= hit && !fifo_full_i;  // full FIFO: drop, schedule unchanged
    end
  end

  assign fifo_wr_o   = wr_q;
  assign fifo_data_o = wr_q ? REPEAT_CODE : '0;
endmodule

// File: rtl/key_autorepeat_chk.sv
module key_autorepeat_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       tick_i,
  input logic       key_evt_i,
  input logic       key_held_i,
  input logic       fifo_full_i,
  input logic       fifo_wr_o,
  input logic [7:0] fifo_data_o
);
  // R2
  code_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> (fifo_data_o == 8'h7E));

  // R2
  idle_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_wr_o |-> (fifo_data_o == 8'h00));

  // R3
  enable_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> $past(en_i));

  // R7
  held_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> $past(key_held_i));

  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !$past(fifo_full_i));

  // R6
  event_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !$past(key_evt_i));

  // R9
  tick_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> $past(tick_i));

  // R9
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |=> !fifo_wr_o);
endmodule

bind key_autorepeat key_autorepeat_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (cfg_i[7]),
  .tick_i      (tick_i),
  .key_evt_i   (key_evt_i),
  .key_held_i  (key_held_i),
  .fifo_full_i (fifo_full_i),
  .fifo_wr_o   (fifo_wr_o),
  .fifo_data_o (fifo_data_o)
);

// File: tb/key_autorepeat_tb_top.sv
`timescale 1ns/1ps
module key_autorepeat_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] cfg_i = 8'h00;
  logic       tick_i = 1'b0;
  logic       key_evt_i = 1'b0;
  logic       key_held_i = 1'b0;
  logic       fifo_full_i = 1'b0;
  logic       fifo_wr_o;
  logic [7:0] fifo_data_o;

  int checks = 0;
  int errors = 0;
  localparam int NEVER = 1000000;

  always #2.5 clk_i = ~clk_i;

  key_autorepeat dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .tick_i(tick_i),
    .key_evt_i(key_evt_i), .key_held_i(key_held_i), .fifo_full_i(fifo_full_i),
    .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o)
  );

  task automatic check(input logic act_wr, input logic exp_wr, input string req);
    checks++;
    if (act_wr !== exp_wr) begin
      errors++;
      $display("FAIL %s wr actual %0b expected %0b at %0t", req, act_wr, exp_wr, $time);
    end
    checks++;
    if (fifo_data_o !== (exp_wr ? 8'h7E : 8'h00)) begin
      errors++;
      $display("FAIL R2 data actual %02h expected %02h at %0t", fifo_data_o,
               exp_wr ? 8'h7E : 8'h00, $time);
    end
  endtask

  // drive inputs for one edge, sample 1ns after it
  task automatic cyc(input logic t, input logic e);
    tick_i = t; key_evt_i = e;
    @(posedge clk_i); #1;
    tick_i = 1'b0; key_evt_i = 1'b0;
  endtask

  function automatic logic due(int k, int d, int r);
    return (k == d) || (k > d && ((k - d) % r) == 0);
  endfunction

  // ticks k0+1..k0+n of a sequence; gap idle cycles after each
  task automatic ticks(int k0, int n, int d, int r, int gap, int full_k, string req);
    for (int k = k0 + 1; k <= k0 + n; k++) begin
      fifo_full_i = (k == full_k);
      cyc(1'b1, 1'b0);
      fifo_full_i = 1'b0;
      check(fifo_wr_o, due(k, d, r) && (k != full_k), req);
      for (int g = 0; g < gap; g++) begin
        cyc(1'b0, 1'b0);
        check(fifo_wr_o, 1'b0, "R9");
      end
    end
  endtask

  function automatic int dval(logic [7:0] c); return (int'(c[3:0]) + 1) * 8; endfunction
  function automatic int rval(logic [7:0] c); return (int'(c[6:4]) + 1) * 4; endfunction

  task automatic start_evt(input logic [7:0] c);
    cfg_i = c; key_held_i = 1'b1;
    cyc(1'b0, 1'b1);
    check(fifo_wr_o, 1'b0, "R6");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] c;
    repeat (3) @(posedge clk_i);
    #1;
    check(fifo_wr_o, 1'b0, "R1");
    rst_ni = 1'b1;
    cyc(1'b1, 1'b0);
    check(fifo_wr_o, 1'b0, "R1");

    // R4 R5: sweep all delay/period codes, tick every cycle
    for (int i = 0; i < 128; i++) begin
      c = 8'h80 | 8'(i);
      start_evt(c);
      ticks(0, dval(c) + 3 * rval(c), dval(c), rval(c), 0, NEVER, "R4_R5");
    end

    // R9: sparse ticks
    for (int i = 0; i < 128; i += 37) begin
      c = 8'h80 | 8'(i);
      start_evt(c);
      ticks(0, dval(c) + 2 * rval(c), dval(c), rval(c), 2, NEVER, "R9");
    end

    // R3: disabled, key held, events and ticks
    start_evt(8'h00);
    ticks(0, 300, NEVER, 4, 0, NEVER, "R3");

    // R3: disable mid-sequence, then re-enable
    c = 8'h91;
    start_evt(c);
    ticks(0, dval(c) + rval(c) - 1, dval(c), rval(c), 0, NEVER, "R3");
    cfg_i = 8'h11;
    ticks(0, 200, NEVER, 4, 0, NEVER, "R3");
    cfg_i = c;
    cyc(1'b0, 1'b0);
    check(fifo_wr_o, 1'b0, "R3");
    ticks(0, dval(c) + rval(c), dval(c), rval(c), 0, NEVER, "R3");

    // R6: event while still held restarts the delay
    c = 8'hA2;
    start_evt(c);
    ticks(0, dval(c) + rval(c) + 3, dval(c), rval(c), 0, NEVER, "R6");
    cyc(1'b0, 1'b1);
    check(fifo_wr_o, 1'b0, "R6");
    ticks(0, dval(c) + 2 * rval(c), dval(c), rval(c), 0, NEVER, "R6");

    // R6: event on the due tick suppresses it
    start_evt(c);
    ticks(0, dval(c) - 1, dval(c), rval(c), 0, NEVER, "R6");
    cyc(1'b1, 1'b1);
    check(fifo_wr_o, 1'b0, "R6");
    ticks(0, dval(c), dval(c), rval(c), 0, NEVER, "R6");

    // R7: release with no key held -> idle; hold again -> fresh delay
    c = 8'h80;
    start_evt(c);
    ticks(0, 5, dval(c), rval(c), 0, NEVER, "R7");
    key_held_i = 1'b0;
    cyc(1'b0, 1'b1);
    check(fifo_wr_o, 1'b0, "R7");
    for (int i = 0; i < 300; i++) begin
      cyc(1'b1, (i % 50) == 0);
      check(fifo_wr_o, 1'b0, "R7");
    end
    key_held_i = 1'b1;
    cyc(1'b0, 1'b0);
    check(fifo_wr_o, 1'b0, "R4");
    ticks(0, dval(c) + rval(c), dval(c), rval(c), 0, NEVER, "R4");

    // R8: FIFO full on first due tick, then on a repeat tick
    c = 8'hB3;
    start_evt(c);
    ticks(0, dval(c) + 2 * rval(c), dval(c), rval(c), 0, dval(c), "R8");
    start_evt(c);
    ticks(0, dval(c) + 3 * rval(c), dval(c), rval(c), 0, dval(c) + rval(c), "R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule